// File: doc/BRIEF.md
# Thread Block Dispatcher

This block hands a stream of thread blocks, strictly in arrival order, to a small set of multithreaded compute cores. The upstream side offers one block at a time with a valid/ready handshake; each offer carries the block's thread count and an identifier. Every core keeps three resource pools: resident block slots, resident threads, and warp slots. A block takes one warp slot per started group of 32 threads. A block is placed only on a core whose three pools can all absorb it. When the head block fits nowhere, the dispatcher holds ready low until a core frees enough room. Later blocks never overtake it.

Cores report finished blocks by naming the core and the resident slot the block was given at dispatch. The dispatcher keeps the thread count of every occupied slot, so completions may arrive in any order and still return exactly the right amount to each pool. When several cores can take the head block, a rotating pointer picks among them so that work spreads across the cores.

A small state machine records the outcome of each cycle's offer and drives the outputs from it. It has four states. IDLE means no block was offered. GRANT means a block was placed, and the dispatch outputs pulse. REJECT means an offered block had an illegal size and was dropped. STALL means the head block fit on no core. The machine moves from any state to any of the four on every clock edge, as follows:
- to GRANT on an accepted, legal block;
- to REJECT on an accepted, illegal block;
- to STALL on an offer refused for lack of room;
- to IDLE when nothing is offered.

Top module: `blk_dispatcher`

## Requirements
- R1: A block offer with a thread count of 0 or above 512 is accepted (ready high) and dropped. One cycle later rej_valid pulses and disp_valid stays low. The drop uses no resources and does not move the rotating pointer.
- R2: A core never holds more than 8 resident blocks. A legal offer is refused (ready low) when every core already holds 8.
- R3: A block needs ceil(threads/32) warp slots. A core accepts it only if both limits still hold after adding the block: resident threads at most 768, and resident warp slots at most 24.
- R4: If the head block fits on no core, req_ready stays low and nothing is dispatched for as long as that remains true. No later block is considered.
- R5: Among the cores that can take the block, the first one at or after the rotating pointer, counting upward with wrap-around, is chosen. After a grant the pointer moves to the core after the chosen one.
- R6: One cycle after an accepted legal block, disp_valid pulses for one cycle. At the same time disp_core gives the chosen core, disp_slot gives the lowest-numbered free resident slot on that core, and disp_id gives the block's identifier.
- R7: A completion naming an occupied slot frees that slot together with its threads and warp slots, and the freed room counts for admission from the next cycle. A completion naming an empty slot changes nothing.
- R8: A dispatch and a completion in the same cycle both take effect, and no per-core counter wraps.
- R9: After reset every core is empty, the pointer is at core 0, and disp_valid and rej_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A block is offered |
| req_ready | output | 1 | The offered block is taken this cycle |
| req_threads | input | 10 | Thread count of the offered block |
| req_id | input | 16 | Identifier of the offered block |
| done_valid | input | 1 | A core reports a finished block |
| done_core | input | 2 | Core of the finished block |
| done_slot | input | 3 | Resident slot of the finished block |
| disp_valid | output | 1 | Dispatch result pulse |
| disp_core | output | 2 | Core the block was placed on |
| disp_slot | output | 3 | Resident slot given to the block |
| disp_id | output | 16 | Identifier of the dispatched block |
| rej_valid | output | 1 | Illegal block was dropped |

## Verification
req_ready is combinational. It is due in the same cycle as the offer, so the bench reads it shortly after driving inputs on the falling edge. disp_valid, disp_core, disp_slot, disp_id and rej_valid come from registers and are due one clock edge after the handshake. The bench samples them on the next falling edge, after removing the offer. A completion updates the pools on the edge that samples it. The bench therefore presents the next dependent offer no earlier than the following cycle. It checks the same-cycle dispatch and completion case by driving both on one falling edge.

// File: rtl/blk_disp_pkg.sv
package blk_disp_pkg;

    // Outcome of the offer seen on the last clock edge
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GRANT  = 2'd1,
        ST_REJECT = 2'd2,
        ST_STALL  = 2'd3
    } disp_state_e;

endpackage

// File: rtl/blk_rr_pick.sv
module blk_rr_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     cand,
    input  logic [IDX_W-1:0] ptr,
    output logic             any,
    output logic [IDX_W-1:0] pick
);

    // Scan from the farthest offset down so the nearest candidate wins
    always_comb begin
        any  = 1'b0;
        pick = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int idx;
            idx = (int'(ptr) + k) % N;
            if (cand[idx]) begin
                any  = 1'b1;
                pick = IDX_W'(idx);
            end
        end
    end

endmodule

// File: rtl/blk_core_pool.sv
module blk_core_pool #(
    parameter int MAX_BLOCKS  = 8,
    parameter int MAX_THREADS = 768,
    parameter int MAX_WARPS   = 24,
    parameter int WARP_SIZE   = 32,
    parameter int THR_W       = 10,
    parameter int WRP_W       = 5,
    parameter int SLOT_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [THR_W-1:0]  need_thr,
    input  logic [WRP_W-1:0]  need_wrp,
    input  logic              alloc_en,
    input  logic              rel_en,
    input  logic [SLOT_W-1:0] rel_slot,
    output logic              fits,
    output logic [SLOT_W-1:0] open_slot
);

    localparam int CNT_W     = $clog2(MAX_BLOCKS + 1);
    localparam int TU_W      = $clog2(MAX_THREADS + 1);
    localparam int WU_W      = $clog2(MAX_WARPS + 1);
    localparam int WARP_LOG2 = $clog2(WARP_SIZE);

    logic [MAX_BLOCKS-1:0] busy_q;
    logic [THR_W-1:0]      slot_thr_q [MAX_BLOCKS];
    logic [CNT_W-1:0]      blk_cnt_q;
    logic [TU_W-1:0]       thr_used_q;
    logic [WU_W-1:0]       wrp_used_q;

    logic             rel_ok;
    logic [THR_W-1:0] rel_thr;
    logic [WRP_W-1:0] rel_wrp;
    logic [THR_W:0]   rel_round;

    // Lowest free resident slot
    always_comb begin
        open_slot = '0;
        for (int s = MAX_BLOCKS - 1; s >= 0; s--) begin
            if (!busy_q[s]) begin
                open_slot = SLOT_W'(s);
            end
        end
    end

    // A completion counts only when it names an occupied slot
    always_comb begin
        rel_ok  = 1'b0;
        rel_thr = '0;
        for (int s = 0; s < MAX_BLOCKS; s++) begin
            if (rel_en && (rel_slot == SLOT_W'(s)) && busy_q[s]) begin
                rel_ok  = 1'b1;
                rel_thr = slot_thr_q[s];
            end
        end
    end

    assign rel_round = {1'b0, rel_thr} + (THR_W + 1)'(WARP_SIZE - 1);
    assign rel_wrp   = WRP_W'(rel_round >> WARP_LOG2);

    // Admission against all three limits, using the current occupancy
    always_comb begin
        fits = (blk_cnt_q < CNT_W'(MAX_BLOCKS))
            && ((32'(thr_used_q) + 32'(need_thr)) <= 32'(MAX_THREADS))
            && ((32'(wrp_used_q) + 32'(need_wrp)) <= 32'(MAX_WARPS));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= '0;
            blk_cnt_q  <= '0;
            thr_used_q <= '0;
            wrp_used_q <= '0;
            for (int s = 0; s < MAX_BLOCKS; s++) begin
                slot_thr_q[s] <= '0;
            end
        end else begin
            if (alloc_en) begin
                busy_q[open_slot]     <= 1'b1;
                slot_thr_q[open_slot] <= need_thr;
            end
            if (rel_ok) begin
                busy_q[rel_slot] <= 1'b0;
            end
            blk_cnt_q  <= blk_cnt_q + CNT_W'(alloc_en) - CNT_W'(rel_ok);
            thr_used_q <= thr_used_q
                        + (alloc_en ? TU_W'(need_thr) : '0)
                        - (rel_ok   ? TU_W'(rel_thr)  : '0);
            wrp_used_q <= wrp_used_q
                        + (alloc_en ? WU_W'(need_wrp) : '0)
                        - (rel_ok   ? WU_W'(rel_wrp)  : '0);
        end
    end

    // R2
    blk_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_cnt_q <= CNT_W'(MAX_BLOCKS));

    // R2
    slot_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(blk_cnt_q) == $countones(busy_q));

    // R3
    thr_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(thr_used_q) <= 32'(MAX_THREADS));

    // R3
    wrp_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(wrp_used_q) <= 32'(MAX_WARPS));

    // R3
    alloc_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> fits);

    // R8
    swap_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && rel_ok) |=> (blk_cnt_q == $past(blk_cnt_q)));

endmodule

// File: rtl/blk_dispatcher.sv
module blk_dispatcher
    import blk_disp_pkg::*;
#(
    parameter int NUM_CORES       = 4,
    parameter int MAX_BLOCKS      = 8,
    parameter int MAX_THREADS     = 768,
    parameter int MAX_WARPS       = 24,
    parameter int WARP_SIZE       = 32,
    parameter int MAX_BLK_THREADS = 512,
    parameter int ID_W            = 16,
    localparam int THR_W  = $clog2(MAX_BLK_THREADS + 1),
    localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int SLOT_W = (MAX_BLOCKS > 1) ? $clog2(MAX_BLOCKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [THR_W-1:0]  req_threads,
    input  logic [ID_W-1:0]   req_id,
    input  logic              done_valid,
    input  logic [CORE_W-1:0] done_core,
    input  logic [SLOT_W-1:0] done_slot,
    output logic              disp_valid,
    output logic [CORE_W-1:0] disp_core,
    output logic [SLOT_W-1:0] disp_slot,
    output logic [ID_W-1:0]   disp_id,
    output logic              rej_valid
);

    localparam int WARP_LOG2 = $clog2(WARP_SIZE);
    localparam int WRP_W     = $clog2(MAX_BLK_THREADS / WARP_SIZE + 2);

    disp_state_e state_q, state_d;

    logic [CORE_W-1:0] ptr_q;
    logic [CORE_W-1:0] core_q;
    logic [SLOT_W-1:0] slot_q;
    logic [ID_W-1:0]   id_q;

    logic [THR_W:0]        thr_round;
    logic [WRP_W-1:0]      req_warps;
    logic                  bad_len;
    logic                  take;
    logic                  grant;
    logic [NUM_CORES-1:0]  core_fit;
    logic [NUM_CORES-1:0]  alloc_en;
    logic [NUM_CORES-1:0]  rel_en;
    logic [SLOT_W-1:0]     core_slot [NUM_CORES];
    logic                  any_fit;
    logic [CORE_W-1:0]     pick;

    assign thr_round = {1'b0, req_threads} + (THR_W + 1)'(WARP_SIZE - 1);
    assign req_warps = WRP_W'(thr_round >> WARP_LOG2);
    assign bad_len   = (req_threads == '0) || (32'(req_threads) > 32'(MAX_BLK_THREADS));

    // One resource pool per core
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        assign rel_en[c]   = done_valid && (done_core == CORE_W'(c));
        assign alloc_en[c] = grant && (pick == CORE_W'(c));

        blk_core_pool #(
            .MAX_BLOCKS  (MAX_BLOCKS),
            .MAX_THREADS (MAX_THREADS),
            .MAX_WARPS   (MAX_WARPS),
            .WARP_SIZE   (WARP_SIZE),
            .THR_W       (THR_W),
            .WRP_W       (WRP_W),
            .SLOT_W      (SLOT_W)
        ) u_pool (
            .clk       (clk),
            .rst_n     (rst_n),
            .need_thr  (req_threads),
            .need_wrp  (req_warps),
            .alloc_en  (alloc_en[c]),
            .rel_en    (rel_en[c]),
            .rel_slot  (done_slot),
            .fits      (core_fit[c]),
            .open_slot (core_slot[c])
        );
    end

    blk_rr_pick #(
        .N     (NUM_CORES),
        .IDX_W (CORE_W)
    ) u_pick (
        .cand (core_fit),
        .ptr  (ptr_q),
        .any  (any_fit),
        .pick (pick)
    );

    assign req_ready = bad_len || any_fit;
    assign take      = req_valid && req_ready;
    assign grant     = take && !bad_len;

    // Next state: outcome of this cycle's offer
    always_comb begin
        if (!req_valid) begin
            state_d = ST_IDLE;
        end else if (bad_len) begin
            state_d = ST_REJECT;
        end else if (any_fit) begin
            state_d = ST_GRANT;
        end else begin
            state_d = ST_STALL;
        end
    end

    // State register and dispatch record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            core_q  <= '0;
            slot_q  <= '0;
            id_q    <= '0;
        end else begin
            state_q <= state_d;
            if (grant) begin
                core_q <= pick;
                slot_q <= core_slot[pick];
                id_q   <= req_id;
                ptr_q  <= (32'(pick) == NUM_CORES - 1) ? '0 : pick + CORE_W'(1);
            end
        end
    end

    // Outputs from state
    always_comb begin
        disp_valid = 1'b0;
        rej_valid  = 1'b0;
        disp_core  = core_q;
        disp_slot  = slot_q;
        disp_id    = id_q;
        unique case (state_q)
            ST_IDLE:   ;
            ST_GRANT:  disp_valid = 1'b1;
            ST_REJECT: rej_valid  = 1'b1;
            ST_STALL:  ;
        endcase
    end

    // R1
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && bad_len) |=> (rej_valid && !disp_valid));

    // R4
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> !disp_valid);

    // R5
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc_en));

    // R5
    pick_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> core_fit[pick]);

    // R6
    grant_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> (disp_valid && (disp_id == $past(req_id))));

endmodule

// File: tb/blk_dispatcher_tb.sv
`timescale 1ns/1ps
module blk_dispatcher_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [9:0]  req_threads = '0;
    logic [15:0] req_id = '0;
    logic        done_valid = 1'b0;
    logic [1:0]  done_core = '0;
    logic [2:0]  done_slot = '0;
    logic        disp_valid;
    logic [1:0]  disp_core;
    logic [2:0]  disp_slot;
    logic [15:0] disp_id;
    logic        rej_valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    blk_dispatcher u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_threads (req_threads),
        .req_id      (req_id),
        .done_valid  (done_valid),
        .done_core   (done_core),
        .done_slot   (done_slot),
        .disp_valid  (disp_valid),
        .disp_core   (disp_core),
        .disp_slot   (disp_slot),
        .disp_id     (disp_id),
        .rej_valid   (rej_valid)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; done_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Placement encoded as core*16+slot
    task automatic push_ok(input int thr, input int id, input int ec, input int es,
                           input string req);
        @(negedge clk);
        req_valid = 1'b1; req_threads = 10'(thr); req_id = 16'(id);
        #1;
        check(req_ready === 1'b1, req, "ready on legal fit", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        check(disp_valid === 1'b1 && disp_id == 16'(id), req, "dispatch pulse/id",
              int'(disp_id), id);
        check(int'(disp_core) * 16 + int'(disp_slot) == ec * 16 + es, req, "core*16+slot",
              int'(disp_core) * 16 + int'(disp_slot), ec * 16 + es);
    endtask

    task automatic push_stall(input int thr, input int cycles, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_threads = 10'(thr); req_id = 16'hdead;
        for (int i = 0; i < cycles; i++) begin
            #1;
            check(req_ready === 1'b0, req, "ready while blocked", int'(req_ready), 0);
            @(negedge clk);
            check(disp_valid === 1'b0, req, "no dispatch while blocked", int'(disp_valid), 0);
        end
        req_valid = 1'b0;
    endtask

    task automatic push_bad(input int thr, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_threads = 10'(thr); req_id = 16'hbad0;
        #1;
        check(req_ready === 1'b1, req, "ready on illegal size", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        check(rej_valid === 1'b1 && disp_valid === 1'b0, req, "reject pulse",
              int'(rej_valid) * 2 + int'(disp_valid), 2);
    endtask

    task automatic release_slot(input int core, input int slot);
        @(negedge clk);
        done_valid = 1'b1; done_core = 2'(core); done_slot = 3'(slot);
        @(negedge clk);
        done_valid = 1'b0;
    endtask

    // R9: reset state and first placement
    task automatic t_reset();
        do_reset();
        #1;
        check(disp_valid === 1'b0 && rej_valid === 1'b0, "R9", "outputs after reset",
              int'(disp_valid) + int'(rej_valid), 0);
        push_ok(1, 7, 0, 0, "R9");
    endtask

    // R5 / R6: rotating spread and lowest free slot
    task automatic t_rotate();
        do_reset();
        for (int i = 0; i < 5; i++) begin
            push_ok(32, 100 + i, i % 4, i / 4, "R5");
        end
        // R1: illegal sizes dropped without moving the pointer
        push_bad(0, "R1");
        push_bad(513, "R1");
        push_ok(512, 200, 1, 1, "R1");
    endtask

    // R2 / R4 / R7: block-slot limit, blocking, release
    task automatic t_block_limit();
        do_reset();
        release_slot(1, 2);             // R7: empty slot, ignored
        for (int i = 0; i < 32; i++) begin
            push_ok(1, 300 + i, i % 4, i / 4, "R2");
        end
        push_stall(1, 4, "R4");
        release_slot(2, 5);
        push_ok(1, 400, 2, 5, "R7");
        push_stall(1, 1, "R2");
    endtask

    // R3: warp rounding and warp limit
    task automatic t_warp_limit();
        do_reset();
        for (int i = 0; i < 4; i++) begin
            push_ok(512, 500 + i, i, 0, "R3");
        end
        push_stall(512, 2, "R3");
        for (int i = 0; i < 16; i++) begin
            push_ok(33, 600 + i, i % 4, 1 + i / 4, "R3");
        end
        push_stall(1, 2, "R3");
        release_slot(1, 2);
        push_ok(64, 700, 1, 2, "R7");
        push_stall(1, 1, "R3");
    endtask

    // R8: dispatch and completion in one cycle
    task automatic t_same_cycle();
        do_reset();
        for (int i = 0; i < 31; i++) begin
            push_ok(1, 800 + i, i % 4, i / 4, "R8");
        end
        @(negedge clk);
        req_valid = 1'b1; req_threads = 10'd1; req_id = 16'd900;
        done_valid = 1'b1; done_core = 2'd0; done_slot = 3'd0;
        #1;
        check(req_ready === 1'b1, "R8", "ready with release", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0; done_valid = 1'b0;
        check(disp_valid === 1'b1 && int'(disp_core) * 16 + int'(disp_slot) == 3 * 16 + 7,
              "R8", "core*16+slot", int'(disp_core) * 16 + int'(disp_slot), 55);
        push_ok(1, 901, 0, 0, "R8");
        push_stall(1, 1, "R8");
    endtask

    initial begin
        t_reset();
        t_rotate();
        t_block_limit();
        t_warp_limit();
        t_same_cycle();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule